// File: doc/BRIEF.md
# Reset Strap Configuration Latch

The block reads eight active-low configuration straps once per external reset and keeps the decoded settings for the rest of the run. It does not sample the straps while the external reset request is high. A small sequencer waits for the request to fall, counts rising clock edges, and loads the decoded straps on the fourth edge. That edge falls inside the window in which the board keeps the straps steady. On the same edge the block raises a one-cycle valid strobe.

An internal watchdog reset request never causes a new sample. The settings latched before it stay in place.

The decoded outputs are:
- a CPU clock-multiplier code;
- a USB clock-source code, plus an error flag for the unused strap combination;
- the address-on-multiplexed-bus decision, which combines the address strap with the live software DA bit;
- the upper-region 8-bit flag;
- the external-transceiver enable;
- a sticky flag that requests tri-state on every pin.

Sequencer states:
- `ST_HELD`: the external reset request is high. Every output shows the default decode.
- `ST_HOLD_WIN`: the request has fallen and the edge counter is running.
- `ST_LOCKED`: the configuration is latched.
- `ST_WDT`: a watchdog reset is in progress and the latch is frozen.

Transitions:
- Every state goes to `ST_HELD` while the external request is high.
- `ST_HELD` goes to `ST_HOLD_WIN` on the first edge with the request low.
- `ST_HOLD_WIN` goes to `ST_LOCKED` on the capture edge.
- `ST_LOCKED` goes to `ST_WDT` while the watchdog request is high.
- `ST_WDT` returns to `ST_LOCKED` when the watchdog request falls.

Top module: `cfg_strap_latch`

## Requirements
- R1: While `ext_rst_req` is high, the outputs show the default decode: `cpu_pll_mode`=0, `usb_clk_mode`=0, `usb_cfg_err`=0, `upper_8bit`=0, `ext_xcvr_en`=0, `once_tristate`=0 and `cfg_valid`=0. In the same condition, `ad_carries_addr` equals the inverse of `sw_da`.
- R2: After `ext_rst_req` falls, the straps are loaded on the 4th rising clock edge.
  - Until that edge the outputs keep the default decode.
  - `cfg_valid` is high for exactly the one cycle that follows that edge.
- R3: After the capture, any change on `strap_n` has no effect on the outputs.
- R4: `wdt_rst_req` never causes a new sample and never raises `cfg_valid`.
  - The latched settings stay unchanged while it is high and after it falls.
  - A watchdog request that arrives during the hold window has no effect, so the capture still happens on the normal edge.
- R5: The CPU pair is formed as {`strap_n[1]`,`strap_n[2]`}. It decodes to `cpu_pll_mode` as follows: 11 gives 0 (2x), 10 gives 1 (4x), 01 gives 2 (1x), 00 gives 3 (bypass).
- R6: The USB pair is formed as {`strap_n[6]`,`strap_n[7]`}. It decodes to `usb_clk_mode` as follows: 11 gives 0 (system clock, USB PLL off), 10 gives 1 (4x), 01 gives 2 (2x).
- R7: USB pair 00 is the reserved code. It sets `usb_cfg_err`=1 and gives `usb_clk_mode`=0. Every other pair gives `usb_cfg_err`=0.
- R8: A low `strap_n[3]` at capture sets `once_tristate`=1. The flag stays set through watchdog resets and strap changes, and it clears only when `ext_rst_req` is next asserted.
- R9: Address strap `strap_n[0]`:
  - When the latched value is low, `ad_carries_addr`=1 regardless of `sw_da`.
  - When it is high, `ad_carries_addr` is the inverse of `sw_da` and follows `sw_da` in the same cycle.
- R10: A low `strap_n[4]` at capture sets `upper_8bit`=1. A low `strap_n[5]` at capture sets `ext_xcvr_en`=1. A high strap gives 0 in both cases.
- R11: If `ext_rst_req` rises again inside the hold window, no capture takes place. The edge count restarts from the next fall of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_req | input | 1 | External reset request, active high, synchronous |
| wdt_rst_req | input | 1 | Internal watchdog reset request, active high |
| strap_n | input | 8 | Active-low configuration straps |
| sw_da | input | 1 | Software bit; when set, address is kept off the multiplexed bus |
| cpu_pll_mode | output | 2 | CPU clock mode code |
| usb_clk_mode | output | 2 | USB clock-source code |
| usb_cfg_err | output | 1 | Reserved USB code was strapped |
| ad_carries_addr | output | 1 | Multiplexed bus carries address as well as data |
| upper_8bit | output | 1 | Upper memory region uses an 8-bit bus |
| ext_xcvr_en | output | 1 | External USB transceiver selected |
| once_tristate | output | 1 | All pins requested to float |
| cfg_valid | output | 1 | One-cycle strobe on capture |

## Verification
A watchdog reset request can overlap the strap capture edge. The bench provokes this by holding `wdt_rst_req` high for the whole hold window, through the fourth edge and one cycle past it. It then judges that the capture and the valid strobe still land on the normal edge with the decode expected from the straps. It also checks that a later watchdog pulse in the locked state, combined with inverted straps, changes nothing. A second overlap is a fresh external reset arriving inside the hold window; the bench checks that the capture moves to four edges after the new release.

// File: rtl/cfg_strap_pkg.sv
package cfg_strap_pkg;

    localparam int unsigned STRAP_W   = 8;
    localparam int unsigned B_ADDR    = 0;
    localparam int unsigned B_CPU1    = 1;
    localparam int unsigned B_CPU2    = 2;
    localparam int unsigned B_ONCE    = 3;
    localparam int unsigned B_UP8     = 4;
    localparam int unsigned B_XCVR    = 5;
    localparam int unsigned B_USB1    = 6;
    localparam int unsigned B_USB2    = 7;

    typedef enum logic [1:0] {
        CPU_X2     = 2'd0,
        CPU_X4     = 2'd1,
        CPU_X1     = 2'd2,
        CPU_BYPASS = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        USB_SYSCLK = 2'd0,
        USB_X4     = 2'd1,
        USB_X2     = 2'd2
    } usb_mode_e;

    typedef enum logic [1:0] {
        ST_HELD,
        ST_HOLD_WIN,
        ST_LOCKED,
        ST_WDT
    } seq_state_e;

    typedef struct packed {
        cpu_mode_e cpu;
        usb_mode_e usb;
        logic      usb_err;
        logic      ad_force;
        logic      up8;
        logic      xcvr_ext;
        logic      once;
    } strap_cfg_t;

    localparam strap_cfg_t CFG_DEFAULT = '{
        cpu:      CPU_X2,
        usb:      USB_SYSCLK,
        usb_err:  1'b0,
        ad_force: 1'b0,
        up8:      1'b0,
        xcvr_ext: 1'b0,
        once:     1'b0
    };

endpackage

// File: rtl/cfg_strap_seq.sv
module cfg_strap_seq
    import cfg_strap_pkg::*;
#(
    parameter int unsigned CAP_EDGE = 4
) (
    input  logic clk,
    input  logic ext_rst_req,
    input  logic wdt_rst_req,
    output logic capture_o,
    output logic frozen_o
);

    localparam int unsigned CNT_W = (CAP_EDGE > 2) ? $clog2(CAP_EDGE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CAP_EDGE - 1);

    seq_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (ext_rst_req) begin
            state <= ST_HELD;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_HELD: begin
                state_nxt = ST_HOLD_WIN;
                cnt_nxt   = CNT_W'(1);
            end
            ST_HOLD_WIN: begin
                if (cnt == CNT_LAST) begin
                    state_nxt = ST_LOCKED;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_LOCKED: begin
                if (wdt_rst_req) state_nxt = ST_WDT;
            end
            ST_WDT: begin
                if (!wdt_rst_req) state_nxt = ST_LOCKED;
            end
            default: state_nxt = ST_HELD;
        endcase
    end

    always_comb begin
        capture_o = 1'b0;
        frozen_o  = 1'b0;
        unique case (state)
            ST_HELD:     ;
            ST_HOLD_WIN: capture_o = (cnt == CNT_LAST);
            ST_LOCKED:   ;
            ST_WDT:      frozen_o = 1'b1;
            default:     ;
        endcase
    end

    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (ext_rst_req)
        capture_o |=> !capture_o); // R2
    AST_NO_CAPTURE_IN_WDT: assert property (@(posedge clk) disable iff (ext_rst_req)
        frozen_o |=> !capture_o); // R4

endmodule

// File: rtl/cfg_strap_decode.sv
module cfg_strap_decode
    import cfg_strap_pkg::*;
(
    input  logic [STRAP_W-1:0] strap_n,
    output strap_cfg_t         cfg_o
);

    logic [1:0] cpu_pair, usb_pair;

    assign cpu_pair = {strap_n[B_CPU1], strap_n[B_CPU2]};
    assign usb_pair = {strap_n[B_USB1], strap_n[B_USB2]};

    always_comb begin
        cfg_o = CFG_DEFAULT;
        unique case (cpu_pair)
            2'b11: cfg_o.cpu = CPU_X2;
            2'b10: cfg_o.cpu = CPU_X4;
            2'b01: cfg_o.cpu = CPU_X1;
            2'b00: cfg_o.cpu = CPU_BYPASS;
            default: cfg_o.cpu = CPU_X2;
        endcase
        unique case (usb_pair)
            2'b11: cfg_o.usb = USB_SYSCLK;
            2'b10: cfg_o.usb = USB_X4;
            2'b01: cfg_o.usb = USB_X2;
            2'b00: begin
                cfg_o.usb     = USB_SYSCLK;
                cfg_o.usb_err = 1'b1;
            end
            default: cfg_o.usb = USB_SYSCLK;
        endcase
        cfg_o.ad_force = !strap_n[B_ADDR];
        cfg_o.up8      = !strap_n[B_UP8];
        cfg_o.xcvr_ext = !strap_n[B_XCVR];
        cfg_o.once     = !strap_n[B_ONCE];
    end

endmodule

// File: rtl/cfg_strap_hold.sv
module cfg_strap_hold
    import cfg_strap_pkg::*;
(
    input  logic       clk,
    input  logic       ext_rst_req,
    input  logic       capture_i,
    input  logic       frozen_i,
    input  strap_cfg_t cfg_i,
    output strap_cfg_t cfg_q,
    output logic       valid_q
);

    always_ff @(posedge clk) begin
        if (ext_rst_req) begin
            cfg_q   <= CFG_DEFAULT;
            valid_q <= 1'b0;
        end else begin
            valid_q <= capture_i;
            if (capture_i) cfg_q <= cfg_i;
        end
    end

    AST_HOLD_WITHOUT_CAPTURE: assert property (@(posedge clk) disable iff (ext_rst_req)
        !capture_i |=> $stable(cfg_q)); // R3
    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (ext_rst_req)
        frozen_i |=> ($stable(cfg_q) && !valid_q)); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (ext_rst_req)
        valid_q |=> !valid_q); // R2
    AST_ONCE_STICKY: assert property (@(posedge clk) disable iff (ext_rst_req)
        cfg_q.once |=> cfg_q.once); // R8

endmodule

// File: rtl/cfg_strap_latch.sv
module cfg_strap_latch
    import cfg_strap_pkg::*;
#(
    parameter int unsigned CAP_EDGE = 4
) (
    input  logic               clk,
    input  logic               ext_rst_req,
    input  logic               wdt_rst_req,
    input  logic [STRAP_W-1:0] strap_n,
    input  logic               sw_da,
    output logic [1:0]         cpu_pll_mode,
    output logic [1:0]         usb_clk_mode,
    output logic               usb_cfg_err,
    output logic               ad_carries_addr,
    output logic               upper_8bit,
    output logic               ext_xcvr_en,
    output logic               once_tristate,
    output logic               cfg_valid
);

    logic       capture, frozen;
    strap_cfg_t cfg_dec, cfg_q;

    cfg_strap_seq #(.CAP_EDGE(CAP_EDGE)) u_seq (
        .clk        (clk),
        .ext_rst_req(ext_rst_req),
        .wdt_rst_req(wdt_rst_req),
        .capture_o  (capture),
        .frozen_o   (frozen)
    );

    cfg_strap_decode u_dec (
        .strap_n(strap_n),
        .cfg_o  (cfg_dec)
    );

    cfg_strap_hold u_hold (
        .clk        (clk),
        .ext_rst_req(ext_rst_req),
        .capture_i  (capture),
        .frozen_i   (frozen),
        .cfg_i      (cfg_dec),
        .cfg_q      (cfg_q),
        .valid_q    (cfg_valid)
    );

    assign cpu_pll_mode    = cfg_q.cpu;
    assign usb_clk_mode    = cfg_q.usb;
    assign usb_cfg_err     = cfg_q.usb_err;
    assign upper_8bit      = cfg_q.up8;
    assign ext_xcvr_en     = cfg_q.xcvr_ext;
    assign once_tristate   = cfg_q.once;
    assign ad_carries_addr = cfg_q.ad_force | !sw_da;

    AST_ERR_FALLBACK: assert property (@(posedge clk) disable iff (ext_rst_req)
        usb_cfg_err |-> (usb_clk_mode == 2'd0)); // R7
    AST_WDT_NO_VALID: assert property (@(posedge clk) disable iff (ext_rst_req)
        (wdt_rst_req && !cfg_valid && $stable(cpu_pll_mode) && frozen) |=> !cfg_valid); // R4

endmodule

// File: tb/sim_cfg_strap_latch.sv
`timescale 1ns/1ps
module sim_cfg_strap_latch;

    logic       clk = 1'b0;
    logic       ext_rst_req = 1'b1;
    logic       wdt_rst_req = 1'b0;
    logic [7:0] strap_n = 8'hFF;
    logic       sw_da = 1'b0;
    logic [1:0] cpu_pll_mode, usb_clk_mode;
    logic       usb_cfg_err, ad_carries_addr, upper_8bit, ext_xcvr_en;
    logic       once_tristate, cfg_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cfg_strap_latch u0 (
        .clk(clk), .ext_rst_req(ext_rst_req), .wdt_rst_req(wdt_rst_req),
        .strap_n(strap_n), .sw_da(sw_da),
        .cpu_pll_mode(cpu_pll_mode), .usb_clk_mode(usb_clk_mode),
        .usb_cfg_err(usb_cfg_err), .ad_carries_addr(ad_carries_addr),
        .upper_8bit(upper_8bit), .ext_xcvr_en(ext_xcvr_en),
        .once_tristate(once_tristate), .cfg_valid(cfg_valid)
    );

    function automatic int e_cpu(logic [7:0] s);
        case ({s[1], s[2]})
            2'b11: return 0;
            2'b10: return 1;
            2'b01: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int e_usb(logic [7:0] s);
        case ({s[6], s[7]})
            2'b10: return 1;
            2'b01: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int e_err(logic [7:0] s);
        return ({s[6], s[7]} == 2'b00) ? 1 : 0;
    endfunction

    function automatic int e_ad(logic [7:0] s, logic da);
        return (!s[0] || !da) ? 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_default(string req);
        chk({req, " cpu"}, int'(cpu_pll_mode), 0);
        chk({req, " usb"}, int'(usb_clk_mode), 0);
        chk({req, " err"}, int'(usb_cfg_err), 0);
        chk({req, " up8"}, int'(upper_8bit), 0);
        chk({req, " xcvr"}, int'(ext_xcvr_en), 0);
        chk({req, " once"}, int'(once_tristate), 0);
        chk({req, " valid"}, int'(cfg_valid), 0);
        chk({req, " ad"}, int'(ad_carries_addr), sw_da ? 0 : 1);
    endtask

    task automatic chk_cfg(logic [7:0] s, string ctx);
        chk({"R5 cpu ", ctx}, int'(cpu_pll_mode), e_cpu(s));
        chk({"R6 usb ", ctx}, int'(usb_clk_mode), e_usb(s));
        chk({"R7 err ", ctx}, int'(usb_cfg_err), e_err(s));
        chk({"R9 ad ", ctx}, int'(ad_carries_addr), e_ad(s, sw_da));
        chk({"R10 up8 ", ctx}, int'(upper_8bit), s[4] ? 0 : 1);
        chk({"R10 xcvr ", ctx}, int'(ext_xcvr_en), s[5] ? 0 : 1);
        chk({"R8 once ", ctx}, int'(once_tristate), s[3] ? 0 : 1);
    endtask

    // External reset, release with straps s, walk to the capture edge.
    task automatic run_reset(logic [7:0] s, logic wdt_in_window);
        @(negedge clk);
        ext_rst_req = 1'b1;
        wdt_rst_req = 1'b0;
        strap_n     = 8'($urandom);
        repeat (2) @(negedge clk);
        chk_default("R1");
        ext_rst_req = 1'b0;
        strap_n     = s;
        wdt_rst_req = wdt_in_window;
        repeat (3) @(negedge clk);
        chk("R2 before capture valid", int'(cfg_valid), 0);
        chk("R2 before capture once", int'(once_tristate), 0);
        chk("R2 before capture cpu", int'(cpu_pll_mode), 0);
        @(negedge clk);
        chk("R2 valid at capture", int'(cfg_valid), 1);
        chk_cfg(s, wdt_in_window ? "R4 wdt overlap" : "capture");
        @(negedge clk);
        chk("R2 valid one cycle", int'(cfg_valid), 0);
        wdt_rst_req = 1'b0;
    endtask

    task automatic post_checks(logic [7:0] s);
        // R3: strap changes after capture
        for (int k = 0; k < 3; k++) begin
            strap_n = 8'($urandom);
            @(negedge clk);
            chk_cfg(s, "R3 strap change");
            chk("R3 no valid", int'(cfg_valid), 0);
        end
        // R4: watchdog reset with inverted straps
        strap_n     = ~s;
        wdt_rst_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk_cfg(s, "R4 during wdt");
            chk("R4 valid during wdt", int'(cfg_valid), 0);
        end
        wdt_rst_req = 1'b0;
        repeat (2) @(negedge clk);
        chk_cfg(s, "R4 after wdt");
        chk("R4 valid after wdt", int'(cfg_valid), 0);
        // R9: live DA bit
        sw_da = ~sw_da;
        #1;
        chk("R9 da toggle", int'(ad_carries_addr), e_ad(s, sw_da));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (2) @(negedge clk);
        chk_default("R1 power up");
        sw_da = 1'b1;
        #1;
        chk("R1 ad with da set", int'(ad_carries_addr), 0);

        // Directed: every CPU and USB pair
        for (int c = 0; c < 4; c++) begin
            logic [7:0] s;
            s = 8'hFF;
            s[1] = c[1]; s[2] = c[0];
            s[6] = c[0]; s[7] = c[1];
            run_reset(s, 1'b0);
            post_checks(s);
        end

        // Directed: ONCE low, watchdog overlapping the capture edge
        run_reset(8'b1111_0111, 1'b1);
        post_checks(8'b1111_0111);
        chk("R8 once persists", int'(once_tristate), 1);
        @(negedge clk);
        ext_rst_req = 1'b1;
        @(negedge clk);
        chk("R8 once cleared by ext reset", int'(once_tristate), 0);

        // Directed: R11 reassert inside hold window
        begin
            logic [7:0] s2;
            s2 = 8'b0100_1001;
            ext_rst_req = 1'b0;
            strap_n = 8'h00;
            repeat (2) @(negedge clk);
            ext_rst_req = 1'b1;
            @(negedge clk);
            chk("R11 no capture on abort", int'(cfg_valid), 0);
            ext_rst_req = 1'b0;
            strap_n = s2;
            repeat (3) @(negedge clk);
            chk("R11 restart count valid", int'(cfg_valid), 0);
            chk("R11 restart count cpu", int'(cpu_pll_mode), 0);
            @(negedge clk);
            chk("R11 capture after restart", int'(cfg_valid), 1);
            chk_cfg(s2, "R11");
        end

        // Random
        for (int i = 0; i < 40; i++) begin
            logic [7:0] s;
            s = 8'($urandom);
            sw_da = 1'($urandom);
            run_reset(s, 1'($urandom));
            post_checks(s);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule